// File: doc/BRIEF.md
# SAR Control and Freeze Registers

This block holds the run-control state of a cell segmentation-and-reassembly engine. A host reaches it over a simple 32-bit register bus with a word address, a write strobe with write data, and a read strobe with read data. It stores three mode bits: a transmit enable, a receive enable and a filler-cell type select. Both enables come up cleared, so neither direction moves traffic until the host has configured the engine.

Each direction also has a freeze flag. When that direction's completion ring reports that no entry is available, the flag sets and the direction stops. A write of any value to that direction's own clear command address releases it. The gates the block drives are the product of the enable bit and the inverted freeze flag. The transmit gate stops new cells from being fetched from host memory, though cells already buffered still drain to the line. The receive gate makes the engine drop every arriving cell.

The block also records the deepest occupancy seen on the transmit and receive FIFOs. These high-water marks can be read any number of times without change. They restart only when the host writes zero to the register. A bandwidth-table size register of 11 bits completes the map.

Top module: `sar_ctl_regs`

## Requirements
- R1: After reset the control bits, both freeze flags, both high-water marks and the table size are zero, and `tx_fetch_en`, `rx_accept_en` and `filler_sel` are low.
- R2: Word address 0 is the control register. Bit 1 is the transmit enable, bit 2 is the receive enable and bit 5 is the filler select. A read returns only those three bits, with every other bit zero.
- R3: `tx_fetch_en` is high exactly when the transmit enable is 1 and the transmit freeze flag is 0. `rx_accept_en` follows the same rule with the receive enable and the receive freeze flag. A gate can only rise after a host write.
- R4: A high `tx_ring_unavail` (or `rx_ring_unavail`) at a clock edge sets that direction's freeze flag. The gate is low from that edge on, whatever the enable bit, and the flag holds until it is cleared.
- R5: A write of any data to word address 3 clears the transmit freeze flag, and a write to word address 4 clears the receive freeze flag. Clearing one flag leaves the other unchanged. If a ring-unavailable input is high in the same cycle as its clear write, the flag stays set.
- R6: Word address 2 reads the high-water marks: receive in bits 19–10, transmit in bits 9–0, and bits 31–20 zero. Each mark samples its 10-bit occupancy input at every edge and keeps the largest value seen.
- R7: Reading the high-water register does not change it, and a nonzero write to it has no effect. A write of zero clears both marks at that edge, taking priority over the occupancy sampled in the same cycle. Tracking resumes at the next edge.
- R8: Word address 1 is the bandwidth-table size. Bits 10–0 are stored and read back, and bits 31–11 read as zero.
- R9: A read of any word address from 5 upward returns zero, and a write there changes no register. `reg_rdata` is zero whenever `reg_rd` is low.
- R10: `filler_sel` equals the stored control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, combinational from address |
| tx_ring_unavail | input | 1 | Transmit completion ring has no free entry |
| rx_ring_unavail | input | 1 | Receive completion ring has no free entry |
| tx_fifo_level | input | 10 | Live transmit FIFO occupancy |
| rx_fifo_level | input | 10 | Live receive FIFO occupancy |
| tx_fetch_en | output | 1 | Permits fetching new transmit cells from host memory |
| rx_accept_en | output | 1 | Permits accepting cells from the line |
| filler_sel | output | 1 | Filler cell type: 0 unassigned, 1 idle |

## Verification
The assertions assume that the occupancy inputs are valid at every clock edge, since the marks sample them every cycle. The bench changes those inputs only at falling edges. The assertions also assume that each host write is a single-cycle strobe with the address and data held for that cycle, and the bench's write and read tasks drive exactly one such strobe.

The ring-unavailable inputs are free to pulse at any time, including in the same cycle as a clear write. The bench deliberately drives that overlap in both directions so the set-over-clear rule is exercised.

// File: rtl/sar_regs_pkg.sv
package sar_regs_pkg;
  localparam int CTL_OFS    = 0;
  localparam int BWT_OFS    = 1;
  localparam int HWM_OFS    = 2;
  localparam int TXCLR_OFS  = 3;
  localparam int RXCLR_OFS  = 4;
  localparam int TX_EN_BIT  = 1;
  localparam int RX_EN_BIT  = 2;
  localparam int FILL_BIT   = 5;
  localparam int NUM_DIR    = 2;

  // next high-water value: clear wins, otherwise keep the larger
  function automatic logic [15:0] hwm_next(input logic [15:0] cur,
                                            input logic [15:0] lvl,
                                            input logic clr);
    if (clr) return '0;
    return (lvl > cur) ? lvl : cur;
  endfunction
endpackage

// File: rtl/sar_freeze_flag.sv
module sar_freeze_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic frz_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     frz_o <= 1'b0;
    else if (set_i) frz_o <= 1'b1;
    else if (clr_i) frz_o <= 1'b0;
  end
endmodule

// File: rtl/sar_hwm_track.sv
module sar_hwm_track import sar_regs_pkg::*; #(
  parameter int DEPTH_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] level_i,
  input  logic               clr_i,
  output logic [DEPTH_W-1:0] hwm_o
);
  logic [15:0] nxt;
  always_comb nxt = hwm_next(16'(hwm_o), 16'(level_i), clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hwm_o <= '0;
    else        hwm_o <= nxt[DEPTH_W-1:0];
  end
endmodule

// File: rtl/sar_ctl_regs.sv
module sar_ctl_regs import sar_regs_pkg::*; #(
  parameter int ADDR_W  = 4,
  parameter int DEPTH_W = 10,
  parameter int BWT_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  input  logic               reg_rd,
  output logic [31:0]        reg_rdata,
  input  logic               tx_ring_unavail,
  input  logic               rx_ring_unavail,
  input  logic [DEPTH_W-1:0] tx_fifo_level,
  input  logic [DEPTH_W-1:0] rx_fifo_level,
  output logic               tx_fetch_en,
  output logic               rx_accept_en,
  output logic               filler_sel
);
  localparam int HWM_W = 2 * DEPTH_W;

  logic wr_ctl, wr_bwt, wm_clr;
  logic tx_en_q, rx_en_q, fill_q;
  logic [BWT_W-1:0] bwt_q;
  logic [NUM_DIR-1:0] ring_set, clr_cmd, frz;
  logic [DEPTH_W-1:0] levels [NUM_DIR];
  logic [DEPTH_W-1:0] hwm    [NUM_DIR];
  logic [DEPTH_W-1:0] hwm_tx, hwm_rx;

  // address decode
  always_comb begin
    wr_ctl     = reg_wr && (reg_addr == ADDR_W'(CTL_OFS));
    wr_bwt     = reg_wr && (reg_addr == ADDR_W'(BWT_OFS));
    wm_clr     = reg_wr && (reg_addr == ADDR_W'(HWM_OFS)) && (reg_wdata == 32'd0);
    clr_cmd[0] = reg_wr && (reg_addr == ADDR_W'(TXCLR_OFS));
    clr_cmd[1] = reg_wr && (reg_addr == ADDR_W'(RXCLR_OFS));
    ring_set   = {rx_ring_unavail, tx_ring_unavail};
    levels[0]  = tx_fifo_level;
    levels[1]  = rx_fifo_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      fill_q  <= 1'b0;
      bwt_q   <= '0;
    end else begin
      if (wr_ctl) begin
        tx_en_q <= reg_wdata[TX_EN_BIT];
        rx_en_q <= reg_wdata[RX_EN_BIT];
        fill_q  <= reg_wdata[FILL_BIT];
      end
      if (wr_bwt) bwt_q <= reg_wdata[BWT_W-1:0];
    end
  end

  // per-direction freeze flag and high-water tracker
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    sar_freeze_flag u_frz (
      .clk(clk), .rst_n(rst_n),
      .set_i(ring_set[d]), .clr_i(clr_cmd[d]), .frz_o(frz[d])
    );
    sar_hwm_track #(.DEPTH_W(DEPTH_W)) u_hwm (
      .clk(clk), .rst_n(rst_n),
      .level_i(levels[d]), .clr_i(wm_clr), .hwm_o(hwm[d])
    );
  end

  assign hwm_tx       = hwm[0];
  assign hwm_rx       = hwm[1];
  assign tx_fetch_en  = tx_en_q && !frz[0];
  assign rx_accept_en = rx_en_q && !frz[1];
  assign filler_sel   = fill_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        ADDR_W'(CTL_OFS): begin
          reg_rdata[TX_EN_BIT] = tx_en_q;
          reg_rdata[RX_EN_BIT] = rx_en_q;
          reg_rdata[FILL_BIT]  = fill_q;
        end
        ADDR_W'(BWT_OFS): reg_rdata[BWT_W-1:0] = bwt_q;
        ADDR_W'(HWM_OFS): reg_rdata[HWM_W-1:0] = {hwm_rx, hwm_tx};
        default:          reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sar_ctl_regs_chk.sv
module sar_ctl_regs_chk #(
  parameter int DEPTH_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [31:0]        reg_rdata,
  input logic               tx_ring_unavail,
  input logic               rx_ring_unavail,
  input logic [DEPTH_W-1:0] tx_fifo_level,
  input logic [DEPTH_W-1:0] rx_fifo_level,
  input logic               tx_fetch_en,
  input logic               rx_accept_en,
  input logic               filler_sel,
  input logic [1:0]         frz,
  input logic [1:0]         clr_cmd,
  input logic               wm_clr,
  input logic [DEPTH_W-1:0] hwm_tx,
  input logic [DEPTH_W-1:0] hwm_rx
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (!tx_fetch_en && !rx_accept_en && !filler_sel
                               && frz == 2'b00 && hwm_tx == '0 && hwm_rx == '0);
    end
  end

  // R3
  tx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_fetch_en) |-> $past(reg_wr));
  // R3
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_accept_en) |-> $past(reg_wr));
  // R4
  tx_freeze_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ring_unavail |=> !tx_fetch_en);
  // R4
  rx_freeze_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ring_unavail |=> !rx_accept_en);
  // R4
  tx_freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz[0] && !clr_cmd[0]) |=> frz[0]);
  // R5
  tx_freeze_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd[0] && !tx_ring_unavail) |=> !frz[0]);
  // R5
  rx_freeze_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd[1] && !rx_ring_unavail) |=> !frz[1]);
  // R6
  tx_hwm_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wm_clr |=> hwm_tx >= $past(tx_fifo_level));
  // R6
  rx_hwm_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wm_clr |=> hwm_rx >= $past(rx_fifo_level));
  // R7
  hwm_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wm_clr |=> (hwm_tx >= $past(hwm_tx) && hwm_rx >= $past(hwm_rx)));
  // R7
  hwm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wm_clr |=> (hwm_tx == '0 && hwm_rx == '0));
  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == 32'd0);
endmodule

bind sar_ctl_regs sar_ctl_regs_chk #(.DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .tx_ring_unavail(tx_ring_unavail),
  .rx_ring_unavail(rx_ring_unavail), .tx_fifo_level(tx_fifo_level),
  .rx_fifo_level(rx_fifo_level), .tx_fetch_en(tx_fetch_en),
  .rx_accept_en(rx_accept_en), .filler_sel(filler_sel), .frz(frz),
  .clr_cmd(clr_cmd), .wm_clr(wm_clr), .hwm_tx(hwm_tx), .hwm_rx(hwm_rx)
);

// File: tb/sar_ctl_regs_bench.sv
`timescale 1ns/1ps
module sar_ctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        tx_ring_unavail = 1'b0, rx_ring_unavail = 1'b0;
  logic [9:0]  tx_fifo_level = '0, rx_fifo_level = '0;
  logic        tx_fetch_en, rx_accept_en, filler_sel;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sar_ctl_regs u_sar_ctl_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .tx_ring_unavail(tx_ring_unavail), .rx_ring_unavail(rx_ring_unavail),
    .tx_fifo_level(tx_fifo_level), .rx_fifo_level(rx_fifo_level),
    .tx_fetch_en(tx_fetch_en), .rx_accept_en(rx_accept_en),
    .filler_sel(filler_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #0.5;
    d = reg_rdata;
    reg_rd = 1'b0;
    #0.1;
  endtask

  function automatic logic [31:0] hwm_word(input int rxm, input int txm);
    return 32'(rxm * 1024 + txm);
  endfunction

  logic [31:0] d;
  int exp_tx, exp_rx;

  task automatic pulse_ring(input int dir);
    if (dir == 0) tx_ring_unavail = 1'b1; else rx_ring_unavail = 1'b1;
    @(negedge clk);
    tx_ring_unavail = 1'b0; rx_ring_unavail = 1'b0;
  endtask

  function automatic logic gate(input int dir);
    return (dir == 0) ? tx_fetch_en : rx_accept_en;
  endfunction

  task automatic freeze_seq(input int dir);
    int other = 1 - dir;
    logic [3:0] own_clr = (dir == 0) ? 4'd3 : 4'd4;
    logic [3:0] oth_clr = (dir == 0) ? 4'd4 : 4'd3;
    wr(4'd0, 32'h6);
    chk(gate(dir) == 1'b1, "R3 gate on", 32'(gate(dir)), 1);
    pulse_ring(dir);
    chk(gate(dir) == 1'b0, "R4 freeze sets", 32'(gate(dir)), 0);
    chk(gate(other) == 1'b1, "R4 other side running", 32'(gate(other)), 1);
    repeat (5) @(negedge clk);
    chk(gate(dir) == 1'b0, "R4 freeze holds", 32'(gate(dir)), 0);
    wr(oth_clr, 32'h1);
    chk(gate(dir) == 1'b0, "R5 other clear no effect", 32'(gate(dir)), 0);
    wr(own_clr, 32'hDEADBEEF);
    chk(gate(dir) == 1'b1, "R5 clear any data", 32'(gate(dir)), 1);
    // set beats clear in same cycle
    if (dir == 0) tx_ring_unavail = 1'b1; else rx_ring_unavail = 1'b1;
    wr(own_clr, 32'h0);
    tx_ring_unavail = 1'b0; rx_ring_unavail = 1'b0;
    chk(gate(dir) == 1'b0, "R5 set wins over clear", 32'(gate(dir)), 0);
    wr(own_clr, 32'h0);
    chk(gate(dir) == 1'b1, "R5 clear after set", 32'(gate(dir)), 1);
    // freeze while disabled persists through enable
    wr(4'd0, 32'h0);
    pulse_ring(dir);
    wr(4'd0, 32'h6);
    chk(gate(dir) == 1'b0, "R3 enable with freeze", 32'(gate(dir)), 0);
    chk(gate(other) == 1'b1, "R3 other enabled", 32'(gate(other)), 1);
    wr(own_clr, 32'h5);
    chk(gate(dir) == 1'b1, "R3 enable after clear", 32'(gate(dir)), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, checked while reset is held and after release
    chk(!tx_fetch_en && !rx_accept_en && !filler_sel, "R1 outputs in reset",
        {29'd0, tx_fetch_en, rx_accept_en, filler_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 3; a++) begin
      rd(4'(a), d);
      chk(d == 0, "R1 register reset value", d, 0);
    end

    // R2 R3 R10 sweep over control data
    for (int v = 0; v < 256; v++) begin
      logic [31:0] w = 32'(v) | (32'(v) << 8) | 32'hA5000000;
      wr(4'd0, w);
      rd(4'd0, d);
      chk(d == (w & 32'h26), "R2 control readback", d, w & 32'h26);
      chk(tx_fetch_en == w[1], "R3 tx gate", 32'(tx_fetch_en), 32'(w[1]));
      chk(rx_accept_en == w[2], "R3 rx gate", 32'(rx_accept_en), 32'(w[2]));
      chk(filler_sel == w[5], "R10 filler select", 32'(filler_sel), 32'(w[5]));
    end

    // R8 table size
    for (int k = 0; k < 12; k++) begin
      logic [31:0] w = (32'd1 << k) | 32'hFFFFF800;
      wr(4'd1, w);
      rd(4'd1, d);
      chk(d == (w & 32'h7FF), "R8 table size", d, w & 32'h7FF);
    end

    // R9 unmapped
    wr(4'd0, 32'h26);
    for (int a = 5; a < 16; a++) begin
      wr(4'(a), 32'hFFFFFFFF);
      rd(4'(a), d);
      chk(d == 0, "R9 unmapped read", d, 0);
    end
    rd(4'd0, d);
    chk(d == 32'h26, "R9 unmapped write no effect", d, 32'h26);
    reg_addr = 4'd0; #0.5;
    chk(reg_rdata == 0, "R9 rdata idle", reg_rdata, 0);
    @(negedge clk);

    // R4 R5 freeze behaviour per direction
    freeze_seq(0);
    freeze_seq(1);

    // R6 high-water tracking
    exp_tx = 0; exp_rx = 0;
    for (int k = 0; k < 64; k++) begin
      int lt = (k * 97 + 13) % 1024;
      int lr = (k * 211 + 5) % 1024;
      tx_fifo_level = 10'(lt); rx_fifo_level = 10'(lr);
      @(negedge clk);
      if (lt > exp_tx) exp_tx = lt;
      if (lr > exp_rx) exp_rx = lr;
      rd(4'd2, d);
      chk(d == hwm_word(exp_rx, exp_tx), "R6 high-water", d, hwm_word(exp_rx, exp_tx));
    end
    // R7 read and nonzero write leave it unchanged
    tx_fifo_level = 10'd1; rx_fifo_level = 10'd2;
    rd(4'd2, d); rd(4'd2, d);
    @(negedge clk);
    rd(4'd2, d);
    chk(d == hwm_word(exp_rx, exp_tx), "R7 read no clear", d, hwm_word(exp_rx, exp_tx));
    wr(4'd2, 32'h00000001);
    rd(4'd2, d);
    chk(d == hwm_word(exp_rx, exp_tx), "R7 nonzero write ignored", d, hwm_word(exp_rx, exp_tx));
    // R7 zero write clears with priority over same-cycle level
    tx_fifo_level = 10'd5; rx_fifo_level = 10'd9;
    wr(4'd2, 32'h0);
    rd(4'd2, d);
    chk(d == 0, "R7 zero write clears", d, 0);
    @(negedge clk);
    rd(4'd2, d);
    chk(d == hwm_word(9, 5), "R7 tracking resumes", d, hwm_word(9, 5));
    tx_fifo_level = 10'd1023; rx_fifo_level = 10'd0;
    @(negedge clk);
    rd(4'd2, d);
    chk(d == hwm_word(9, 1023), "R6 max occupancy", d, hwm_word(9, 1023));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule